// File: doc/BRIEF.md
# Interrupt Pending Level Resolver

This block holds one pending flag for each interrupt line of a processor. Flags are set by line events and by match pulses from compare timers, and software clears them with an acknowledge mask. Each cycle the block works out which flags may interrupt the processor. A flag qualifies if its line is enabled, or if its line belongs to the non-maskable class. The block then finds the highest priority level whose member lines include a qualifying flag. Only levels strictly above the processor's current threshold count. The result is a registered request flag and the encoded level.

The configuration is fixed by parameters:
- the number of lines, levels and timers;
- a membership mask for each level;
- a two-bit kind for each line;
- the timer-to-line map;
- the non-maskable level.

Kind codes are 0 for level-sensitive, 1 for edge, 2 for non-maskable and 3 for timer. Only kind 0 lines lose their flag when the line drops. The threshold is clamped below the non-maskable level, so a non-maskable request always wins.

The default build has 8 lines and 5 levels, with the non-maskable level at 5. The defaults place lines as follows:

| Level | Lines |
|-------|-------|
| 1 | 0, 2 |
| 2 | 1 |
| 3 | 3, 4 |
| 4 | 5, 7 |
| 5 | 6 |

The default line kinds are:
- level-sensitive: lines 0, 1 and 5;
- edge: lines 2, 3 and 7;
- timer: line 4;
- non-maskable: line 6.

Timer 0 maps to line 4 and timer 1 maps to line 7.

Top module: `irq_level_resolver`

## Requirements
- R1: An in-range event with `evt_active`=1 sets the flag of line `evt_idx`. An event with `evt_active`=0 on a kind-0 (level-sensitive) line clears that flag.
- R2: An event with `evt_active`=0 on a line of kind 1, 2 or 3 leaves its flag set.
- R3: A flag qualifies only if its bit in the enable register is 1 or its line is kind 2 (non-maskable). With enable all zero, maskable flags raise no request.
- R4: A threshold at or above `NMI_LEVEL` acts as `NMI_LEVEL`-1, so a non-maskable flag at `NMI_LEVEL` still raises a request with the threshold at its maximum.
- R5: The reported level is the highest level whose membership mask has a qualifying flag, among levels strictly greater than the effective threshold.
- R6: When no level qualifies, `irq_level` is 0 and `irq_req` is 0. Otherwise `irq_req` is 1 and `irq_level` is non-zero.
- R7: An event whose `evt_idx` is `NUM_IRQ` or more changes no flag.
- R8: A 1 on `timer_match[t]` sets the flag of the line that `TIMER_MAP` assigns to timer t.
- R9: With `ack_valid`=1, each 1 in `ack_mask` clears that flag. A set of the same flag in the same cycle takes priority, and the flag stays set.
- R10: Flags, enable and threshold update on the clock edge that samples the write. The outputs follow on the next edge.
- R11: Synchronous active-high `rst` clears all flags, the enable register, the threshold and both outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Line event strobe |
| evt_idx | input | EVT_IDX_W | Index of the line the event refers to |
| evt_active | input | 1 | 1: line asserted, 0: line released |
| timer_match | input | NUM_TIMERS | Compare-timer match pulses |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_mask | input | NUM_IRQ | Write-one-to-clear mask of pending flags |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | NUM_IRQ | New enable register value |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | LVL_W | New threshold value |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_level | output | LVL_W | Level of the pending request, 0 when none |

## Verification
Assertions check every cycle that a set, a level release, a timer match and an acknowledge each leave the flag they target in the state the rules give. They also check that edge-kind flags survive a release and that out-of-range events leave the flags untouched. On the output side, they check that the request agrees with a non-zero level, that any reported level lies above the clamped threshold, and that the clamped threshold stays below the non-maskable level.

Only the bench scenarios can show the following:
- that the highest qualifying level is the one chosen;
- that enable gating and the non-maskable bypass interact correctly;
- the exact two-edge latency from event to output;
- that a reset clears hidden state such as flags that are not enabled.

// File: rtl/irq_resolver_pkg.sv
package irq_resolver_pkg;

   typedef enum logic [1:0] {
      KIND_LEVEL = 2'd0,
      KIND_EDGE  = 2'd1,
      KIND_NMI   = 2'd2,
      KIND_TIMER = 2'd3
   } irq_kind_e;

   function automatic irq_kind_e kind_of(input logic [1:0] code);
      return irq_kind_e'(code);
   endfunction

endpackage

// File: rtl/irq_pending_reg.sv
module irq_pending_reg
   import irq_resolver_pkg::*;
#(
   parameter int NUM_IRQ    = 8,
   parameter int NUM_TIMERS = 2,
   parameter int IRQ_W      = 3,
   parameter int EVT_IDX_W  = 4,
   parameter logic [2*NUM_IRQ-1:0]      IRQ_KINDS = '0,
   parameter logic [NUM_TIMERS*IRQ_W-1:0] TIMER_MAP = '0
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  evt_valid,
   input  logic [EVT_IDX_W-1:0]  evt_idx,
   input  logic                  evt_active,
   input  logic [NUM_TIMERS-1:0] timer_match,
   input  logic                  ack_valid,
   input  logic [NUM_IRQ-1:0]    ack_mask,
   output logic [NUM_IRQ-1:0]    pend_q
);

   logic [NUM_IRQ-1:0] lvl_kind;
   logic [NUM_IRQ-1:0] evt_sel;
   logic [NUM_IRQ-1:0] set_vec;
   logic [NUM_IRQ-1:0] clr_vec;
   logic [NUM_IRQ-1:0] ack_vec;
   logic [NUM_IRQ-1:0] pend_d;
   logic               evt_inr;
   logic [IRQ_W-1:0]   evt_bit;

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_kind
      assign lvl_kind[i] = (kind_of(IRQ_KINDS[2*i +: 2]) == KIND_LEVEL);
   end

   assign evt_inr = evt_valid && ({1'b0, evt_idx} < (EVT_IDX_W+1)'(NUM_IRQ));
   assign evt_bit = evt_idx[IRQ_W-1:0];

   always_comb begin
      for (int i = 0; i < NUM_IRQ; i++) begin
         evt_sel[i] = evt_inr && (evt_idx == EVT_IDX_W'(i));
      end
   end

   always_comb begin
      set_vec = evt_active ? evt_sel : '0;
      for (int t = 0; t < NUM_TIMERS; t++) begin
         if (timer_match[t]) begin
            set_vec[TIMER_MAP[t*IRQ_W +: IRQ_W]] = 1'b1;
         end
      end
   end

   assign clr_vec = evt_active ? '0 : (evt_sel & lvl_kind);
   assign ack_vec = ack_valid ? ack_mask : '0;
   assign pend_d  = (pend_q & ~ack_vec & ~clr_vec) | set_vec;

   always_ff @(posedge clk) begin
      if (rst) pend_q <= '0;
      else     pend_q <= pend_d;
   end

   assert_evt_sets_R1: assert property (@(posedge clk) disable iff (rst)
      evt_inr && evt_active |=> pend_q[$past(evt_bit)]);

   assert_level_release_R1: assert property (@(posedge clk) disable iff (rst)
      evt_inr && !evt_active && lvl_kind[evt_bit] && (timer_match == '0)
      |=> !pend_q[$past(evt_bit)]);

   assert_edge_sticky_R2: assert property (@(posedge clk) disable iff (rst)
      evt_inr && !evt_active && !lvl_kind[evt_bit] && !ack_vec[evt_bit]
      |=> pend_q[$past(evt_bit)] == $past(pend_q[evt_bit]));

   assert_out_of_range_R7: assert property (@(posedge clk) disable iff (rst)
      evt_valid && !evt_inr && !ack_valid && (timer_match == '0)
      |=> $stable(pend_q));

   assert_ack_clears_R9: assert property (@(posedge clk) disable iff (rst)
      ack_valid && !evt_valid && (timer_match == '0)
      |=> (pend_q & $past(ack_mask)) == '0);

   for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tchk
      assert_timer_sets_R8: assert property (@(posedge clk) disable iff (rst)
         timer_match[t] |=> pend_q[TIMER_MAP[t*IRQ_W +: IRQ_W]]);
   end

endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs #(
   parameter int NUM_IRQ = 8,
   parameter int LVL_W   = 3
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               en_we,
   input  logic [NUM_IRQ-1:0] en_wdata,
   input  logic               thr_we,
   input  logic [LVL_W-1:0]   thr_wdata,
   output logic [NUM_IRQ-1:0] enable_q,
   output logic [LVL_W-1:0]   thr_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         enable_q <= '0;
         thr_q    <= '0;
      end else begin
         if (en_we)  enable_q <= en_wdata;
         if (thr_we) thr_q    <= thr_wdata;
      end
   end

endmodule

// File: rtl/irq_level_scan.sv
module irq_level_scan
   import irq_resolver_pkg::*;
#(
   parameter int NUM_IRQ    = 8,
   parameter int NUM_LEVELS = 5,
   parameter int NMI_LEVEL  = 5,
   parameter int LVL_W      = 3,
   parameter logic [NUM_LEVELS*NUM_IRQ-1:0] LEVEL_MASKS = '0,
   parameter logic [2*NUM_IRQ-1:0]          IRQ_KINDS   = '0
) (
   input  logic [NUM_IRQ-1:0] pend,
   input  logic [NUM_IRQ-1:0] enable,
   input  logic [LVL_W-1:0]   thr,
   output logic [LVL_W-1:0]   thr_eff,
   output logic               found,
   output logic [LVL_W-1:0]   level
);

   logic [NUM_IRQ-1:0]    nmi_mask;
   logic [NUM_IRQ-1:0]    eligible;
   logic [NUM_LEVELS:1]   lvl_hit;

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_nmi
      assign nmi_mask[i] = (kind_of(IRQ_KINDS[2*i +: 2]) == KIND_NMI);
   end

   assign eligible = pend & (enable | nmi_mask);

   for (genvar l = 1; l <= NUM_LEVELS; l++) begin : g_hit
      assign lvl_hit[l] = |(LEVEL_MASKS[(l-1)*NUM_IRQ +: NUM_IRQ] & eligible);
   end

   assign thr_eff = (thr >= LVL_W'(NMI_LEVEL)) ? LVL_W'(NMI_LEVEL - 1) : thr;

   always_comb begin
      found = 1'b0;
      level = '0;
      for (int l = NUM_LEVELS; l >= 1; l--) begin
         if (!found && lvl_hit[l] && (LVL_W'(l) > thr_eff)) begin
            found = 1'b1;
            level = LVL_W'(l);
         end
      end
   end

endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver
   import irq_resolver_pkg::*;
#(
   parameter int NUM_IRQ    = 8,
   parameter int NUM_LEVELS = 5,
   parameter int NMI_LEVEL  = 5,
   parameter int NUM_TIMERS = 2,
   parameter logic [NUM_LEVELS*NUM_IRQ-1:0] LEVEL_MASKS = 40'h40_A0_18_02_05,
   parameter logic [2*NUM_IRQ-1:0]          IRQ_KINDS   = 16'h6350,
   localparam int IRQ_W     = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
   localparam int EVT_IDX_W = IRQ_W + 1,
   localparam int LVL_W     = $clog2(NUM_LEVELS + 1),
   parameter logic [NUM_TIMERS*IRQ_W-1:0]   TIMER_MAP   = 6'b111_100
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  evt_valid,
   input  logic [EVT_IDX_W-1:0]  evt_idx,
   input  logic                  evt_active,
   input  logic [NUM_TIMERS-1:0] timer_match,
   input  logic                  ack_valid,
   input  logic [NUM_IRQ-1:0]    ack_mask,
   input  logic                  en_we,
   input  logic [NUM_IRQ-1:0]    en_wdata,
   input  logic                  thr_we,
   input  logic [LVL_W-1:0]      thr_wdata,
   output logic                  irq_req,
   output logic [LVL_W-1:0]      irq_level
);

   if (NMI_LEVEL < 1 || NMI_LEVEL > NUM_LEVELS) begin : g_bad_nmi
      $error("NMI_LEVEL must lie within 1..NUM_LEVELS");
   end
   if (NUM_IRQ < 1 || NUM_LEVELS < 1 || NUM_TIMERS < 1) begin : g_bad_count
      $error("counts must be at least one");
   end
   for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_map_chk
      if (TIMER_MAP[t*IRQ_W +: IRQ_W] >= NUM_IRQ) begin : g_bad_map
         $error("TIMER_MAP entry points beyond NUM_IRQ");
      end
   end

   logic [NUM_IRQ-1:0] pend_q;
   logic [NUM_IRQ-1:0] enable_q;
   logic [LVL_W-1:0]   thr_q;
   logic [LVL_W-1:0]   thr_eff;
   logic               scan_found;
   logic [LVL_W-1:0]   scan_level;

   irq_pending_reg #(
      .NUM_IRQ    (NUM_IRQ),
      .NUM_TIMERS (NUM_TIMERS),
      .IRQ_W      (IRQ_W),
      .EVT_IDX_W  (EVT_IDX_W),
      .IRQ_KINDS  (IRQ_KINDS),
      .TIMER_MAP  (TIMER_MAP)
   ) i_pend (
      .clk         (clk),
      .rst         (rst),
      .evt_valid   (evt_valid),
      .evt_idx     (evt_idx),
      .evt_active  (evt_active),
      .timer_match (timer_match),
      .ack_valid   (ack_valid),
      .ack_mask    (ack_mask),
      .pend_q      (pend_q)
   );

   irq_ctrl_regs #(
      .NUM_IRQ (NUM_IRQ),
      .LVL_W   (LVL_W)
   ) i_ctrl (
      .clk       (clk),
      .rst       (rst),
      .en_we     (en_we),
      .en_wdata  (en_wdata),
      .thr_we    (thr_we),
      .thr_wdata (thr_wdata),
      .enable_q  (enable_q),
      .thr_q     (thr_q)
   );

   irq_level_scan #(
      .NUM_IRQ     (NUM_IRQ),
      .NUM_LEVELS  (NUM_LEVELS),
      .NMI_LEVEL   (NMI_LEVEL),
      .LVL_W       (LVL_W),
      .LEVEL_MASKS (LEVEL_MASKS),
      .IRQ_KINDS   (IRQ_KINDS)
   ) i_scan (
      .pend    (pend_q),
      .enable  (enable_q),
      .thr     (thr_q),
      .thr_eff (thr_eff),
      .found   (scan_found),
      .level   (scan_level)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         irq_req   <= 1'b0;
         irq_level <= '0;
      end else begin
         irq_req   <= scan_found;
         irq_level <= scan_level;
      end
   end

   assert_req_has_level_R6: assert property (@(posedge clk) disable iff (rst)
      irq_req |-> irq_level != '0);

   assert_idle_zero_level_R6: assert property (@(posedge clk) disable iff (rst)
      !irq_req |-> irq_level == '0);

   assert_above_threshold_R5: assert property (@(posedge clk) disable iff (rst)
      irq_req |-> irq_level > $past(thr_eff));

   assert_thr_clamped_R4: assert property (@(posedge clk) disable iff (rst)
      thr_eff < LVL_W'(NMI_LEVEL));

   assert_level_bounded_R5: assert property (@(posedge clk) disable iff (rst)
      irq_level <= LVL_W'(NUM_LEVELS));

endmodule

// File: tb/test_irq_level_resolver.sv
module test_irq_level_resolver;

   localparam int NI = 8;
   localparam int LW = 3;
   localparam int IW = 4;
   localparam int NT = 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          evt_valid = 1'b0;
   logic [IW-1:0] evt_idx = '0;
   logic          evt_active = 1'b0;
   logic [NT-1:0] timer_match = '0;
   logic          ack_valid = 1'b0;
   logic [NI-1:0] ack_mask = '0;
   logic          en_we = 1'b0;
   logic [NI-1:0] en_wdata = '0;
   logic          thr_we = 1'b0;
   logic [LW-1:0] thr_wdata = '0;
   logic          irq_req;
   logic [LW-1:0] irq_level;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   irq_level_resolver i_irq_level_resolver (
      .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_idx(evt_idx),
      .evt_active(evt_active), .timer_match(timer_match),
      .ack_valid(ack_valid), .ack_mask(ack_mask), .en_we(en_we),
      .en_wdata(en_wdata), .thr_we(thr_we), .thr_wdata(thr_wdata),
      .irq_req(irq_req), .irq_level(irq_level)
   );

   task automatic chk(input string req, input logic exp_req, input int exp_lvl);
      n_chk++;
      if (irq_req !== exp_req || irq_level !== LW'(exp_lvl)) begin
         n_fail++;
         $display("FAIL %s: req=%0b level=%0d expected req=%0b level=%0d",
                  req, irq_req, irq_level, exp_req, exp_lvl);
      end
   endtask

   task automatic evt(input int idx, input bit act);
      @(negedge clk);
      evt_valid = 1'b1; evt_idx = IW'(idx); evt_active = act;
      @(negedge clk);
      evt_valid = 1'b0; evt_active = 1'b0;
      @(negedge clk);
   endtask

   task automatic ack(input logic [NI-1:0] m);
      @(negedge clk);
      ack_valid = 1'b1; ack_mask = m;
      @(negedge clk);
      ack_valid = 1'b0; ack_mask = '0;
      @(negedge clk);
   endtask

   task automatic wr_en(input logic [NI-1:0] v);
      @(negedge clk);
      en_we = 1'b1; en_wdata = v;
      @(negedge clk);
      en_we = 1'b0;
      @(negedge clk);
   endtask

   task automatic wr_thr(input int v);
      @(negedge clk);
      thr_we = 1'b1; thr_wdata = LW'(v);
      @(negedge clk);
      thr_we = 1'b0;
      @(negedge clk);
   endtask

   task automatic tmr(input logic [NT-1:0] m);
      @(negedge clk);
      timer_match = m;
      @(negedge clk);
      timer_match = '0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk("R11 reset outputs", 1'b0, 0);
      rst = 1'b0;
   endtask

   task automatic t_enable_gate();
      evt(0, 1'b1);
      chk("R3 disabled line blocked", 1'b0, 0);
      wr_en(8'hFF);
      chk("R3 enabled line passes", 1'b1, 1);
      evt(0, 1'b0);
      chk("R1 level line released", 1'b0, 0);
   endtask

   task automatic t_sticky();
      evt(2, 1'b1);
      chk("R1 edge line set", 1'b1, 1);
      evt(2, 1'b0);
      chk("R2 edge line stays after release", 1'b1, 1);
      ack(8'h04);
      chk("R9 ack clears edge flag", 1'b0, 0);
   endtask

   task automatic t_priority();
      evt(2, 1'b1);
      evt(5, 1'b1);
      chk("R5 highest level wins", 1'b1, 4);
      wr_thr(4);
      chk("R5 level equal to threshold excluded", 1'b0, 0);
      wr_thr(3);
      chk("R5 level above threshold", 1'b1, 4);
      wr_thr(0);
      evt(5, 1'b0);
      chk("R5 falls back to lower level", 1'b1, 1);
      ack(8'h04);
      chk("R6 nothing pending", 1'b0, 0);
   endtask

   task automatic t_nmi();
      wr_en(8'h00);
      evt(6, 1'b1);
      chk("R3 nmi ignores enable", 1'b1, 5);
      wr_thr(7);
      chk("R4 threshold clamped below nmi", 1'b1, 5);
      wr_thr(5);
      chk("R4 threshold at nmi level clamped", 1'b1, 5);
      evt(6, 1'b0);
      chk("R2 nmi flag stays after release", 1'b1, 5);
      ack(8'h40);
      chk("R9 nmi acked", 1'b0, 0);
      wr_thr(0);
      wr_en(8'hFF);
   endtask

   task automatic t_range();
      evt(8, 1'b1);
      evt(15, 1'b1);
      evt(9, 1'b0);
      chk("R7 out-of-range events ignored", 1'b0, 0);
   endtask

   task automatic t_timer();
      tmr(2'b01);
      chk("R8 timer0 sets line 4", 1'b1, 3);
      ack(8'h10);
      tmr(2'b10);
      chk("R8 timer1 sets line 7", 1'b1, 4);
      ack(8'h80);
      chk("R9 timer flag acked", 1'b0, 0);
   endtask

   task automatic t_ack_race();
      @(negedge clk);
      evt_valid = 1'b1; evt_idx = 4'd3; evt_active = 1'b1;
      ack_valid = 1'b1; ack_mask = 8'h08;
      @(negedge clk);
      evt_valid = 1'b0; evt_active = 1'b0; ack_valid = 1'b0; ack_mask = '0;
      @(negedge clk);
      chk("R9 set beats same-cycle ack", 1'b1, 3);
      ack(8'h08);
      chk("R9 later ack clears", 1'b0, 0);
   endtask

   task automatic t_latency();
      @(negedge clk);
      evt_valid = 1'b1; evt_idx = 4'd1; evt_active = 1'b1;
      @(negedge clk);
      evt_valid = 1'b0; evt_active = 1'b0;
      chk("R10 output unchanged one edge after event", 1'b0, 0);
      @(negedge clk);
      chk("R10 output updated on second edge", 1'b1, 2);
      evt(1, 1'b0);
      chk("R1 line 1 released", 1'b0, 0);
   endtask

   task automatic t_reset_mid();
      evt(3, 1'b1);
      chk("R1 line 3 set before reset", 1'b1, 3);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R11 reset clears outputs", 1'b0, 0);
      @(negedge clk);
      chk("R11 enable cleared by reset", 1'b0, 0);
      wr_en(8'hFF);
      chk("R11 flags cleared by reset", 1'b0, 0);
   endtask

   initial begin
      t_reset();
      t_enable_gate();
      t_sticky();
      t_priority();
      t_nmi();
      t_range();
      t_timer();
      t_ack_race();
      t_latency();
      t_reset_mid();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule